// File: doc/BRIEF.md
# SPI Digital Potentiometer Register Controller

This block is the digital side of a 1024-position digital potentiometer. It is an SPI slave with a volatile 10-bit wiper register, whose value leaves the block as the tap select for the resistor-array decoder. It also holds four data registers that model nonvolatile storage for saved wiper positions. A bus master first sends an address byte and an instruction byte. Depending on the instruction, it then reads or writes the wiper register or one data register, or moves a value between the wiper register and a data register.

All serial pins are sampled by the block's own clock through a synchronizer and edge detectors. The block therefore runs in one clock domain, and SCK must be several times slower than the system clock. A pause input can stop a transaction midway without losing it. A protect input keeps the data registers from changing but leaves the wiper register writable. After reset the wiper register is loaded from data register 0, and the data registers keep their contents across reset. After reset no frame is decoded until chip select has been seen going from high to low.

Top module: `dpot_spi_ctrl`

## Requirements
- R1: SI is sampled on rising SCK edges and SO changes only on falling SCK edges, MSB first. A read returns a 16-bit word made of six zero bits followed by the 10-bit register value.
- R2: so_oe is high only during the 16-bit data phase of a read frame. It is low at reset, low during the address and instruction bytes, and low once chip select is high.
- R3: After reset, a frame clocked in while chip select has stayed low since reset has no effect. Decoding starts only after a high-to-low chip-select transition.
- R4: hold_n falling while SCK is low pauses the frame: SCK edges are ignored and so_oe is low. hold_n rising while SCK is low resumes the frame where it stopped. hold_n edges while SCK is high have no effect.
- R5: The first byte must equal {4'b0101, strap[1], strap[0], 2'b00}, sent bit 7 first. Any other value makes the block ignore the rest of the frame.
- R6: The instruction byte carries the opcode in bits 7:4 and the data-register index in bits 1:0. The opcodes are 9h read wiper, Ah write wiper, Bh read data register, Ch write data register, Dh copy data register to wiper, Eh copy wiper to data register. In a write the upper 6 bits of the 16-bit data word are ignored.
- R7: The wiper output always equals the wiper register. It changes only after the 16th data bit of a write-wiper frame, after a copy into the wiper, or at the recall that follows reset.
- R8: Each data register can be written and read back, and it keeps its value across reset.
- R9: After reset is released, the wiper register is loaded with the value of data register 0.
- R10: While wp_n is low, writes and copies into any data register are blocked. Wiper writes still take effect.
- R11: An opcode outside the six listed, or chip select rising before a frame is complete, leaves every register unchanged.
- R12: Copy data register n to wiper sets the wiper to that register's value. Copy wiper to data register n stores the wiper value in register n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Transaction pause, active low |
| wp_n | input | 1 | Data-register write protect, active low |
| strap | input | 2 | Board-strapped device address |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| wiper | output | 10 | Wiper tap position |

## Verification
The bench sweeps many wiper values through write and read frames, with non-zero padding bits. A design that used the padding or misordered the bits would show a wrong wiper or a wrong read word. It sends address bytes with the wrong strap, the wrong type code or non-zero low bits, unlisted opcodes, and frames cut short by chip select. A design that decoded any of these would visibly change the wiper or a data register. Pauses are applied in mid-write and mid-read while SCK keeps toggling, and a pause edge is also placed while SCK is high. A design that counted bits during a pause, drove SO while paused, or accepted the high-level edge would corrupt the value. Protect, reset recall and the first chip-select edge after reset are each checked: a design that got any of them wrong would write a protected register, leave the wiper unrecalled, or act on a frame that should have been ignored.

// File: rtl/dpot_pkg.sv
`timescale 1ns/1ps
package dpot_pkg;
  // opcode field of the instruction byte (bits 7:4)
  typedef enum logic [3:0] {
    OP_RD_WCR  = 4'h9,
    OP_WR_WCR  = 4'hA,
    OP_RD_DR   = 4'hB,
    OP_WR_DR   = 4'hC,
    OP_DR2WCR  = 4'hD,
    OP_WCR2DR  = 4'hE
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INSTR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } st_e;
endpackage

// File: rtl/dpot_pin_sync.sv
`timescale 1ns/1ps
module dpot_pin_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dpot_link.sv
`timescale 1ns/1ps
module dpot_link (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  output logic sel,
  output logic rise_ev,
  output logic fall_ev,
  output logic cs_fall,
  output logic cs_rise,
  output logic paused
);
  logic sck_q, csn_q, holdn_q, paused_q, paused_d;
  logic hold_dn, hold_up;

  assign sel     = !cs_n_s;
  // csn_q resets low: a select held low through reset is never seen as a fresh edge
  assign cs_fall = csn_q && !cs_n_s;
  assign cs_rise = !csn_q && cs_n_s;
  assign hold_dn = holdn_q && !hold_n_s && !sck_s;
  assign hold_up = !holdn_q && hold_n_s && !sck_s;

  always_comb begin
    paused_d = paused_q;
    if (cs_n_s)       paused_d = 1'b0;
    else if (hold_dn) paused_d = 1'b1;
    else if (hold_up) paused_d = 1'b0;
  end

  assign rise_ev = sel && !paused_q && sck_s && !sck_q;
  assign fall_ev = sel && !paused_q && !sck_s && sck_q;
  assign paused  = paused_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      csn_q    <= 1'b0;
      holdn_q  <= 1'b1;
      paused_q <= 1'b0;
    end else begin
      sck_q    <= sck_s;
      csn_q    <= cs_n_s;
      holdn_q  <= hold_n_s;
      paused_q <= paused_d;
    end
  end
endmodule

// File: rtl/dpot_cmd.sv
`timescale 1ns/1ps
module dpot_cmd
  import dpot_pkg::*;
#(
  parameter int          WIPER_W  = 10,
  parameter int          WORD_W   = 16,
  parameter int          DR_SEL_W = 2,
  parameter int          STRAP_W  = 2,
  parameter logic [3:0]  DEV_TYPE = 4'b0101
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise_ev,
  input  logic                fall_ev,
  input  logic                cs_fall,
  input  logic                cs_rise,
  input  logic                si_s,
  input  logic [STRAP_W-1:0]  strap,
  input  logic [WIPER_W-1:0]  rd_data,
  output logic                wr_wcr,
  output logic                wr_dr,
  output logic                xfer_d2w,
  output logic                xfer_w2d,
  output logic [DR_SEL_W-1:0] dr_idx,
  output logic [WIPER_W-1:0]  wr_data,
  output logic                rd_src_wcr,
  output logic [DR_SEL_W-1:0] rd_idx,
  output logic                so_bit,
  output logic                so_active,
  output st_e                 fsm_state
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int PAD_W  = WORD_W - WIPER_W;
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

  st_e                 state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [WORD_W-1:0]   shin_q, shin_d, shout_q, shout_d, in_word;
  logic [DR_SEL_W-1:0] idx_q, idx_d;
  logic                todr_q, todr_d, so_q, so_d;
  logic [BYTE_W-1:0]   in_byte, my_addr;

  assign in_word    = {shin_q[WORD_W-2:0], si_s};
  assign in_byte    = in_word[BYTE_W-1:0];
  assign my_addr    = {DEV_TYPE, strap, 2'b00};
  assign rd_idx     = in_byte[DR_SEL_W-1:0];
  assign dr_idx     = (state_q == ST_INSTR) ? in_byte[DR_SEL_W-1:0] : idx_q;
  assign wr_data    = in_word[WIPER_W-1:0];
  assign so_bit     = so_q;
  assign so_active  = (state_q == ST_RDATA);
  assign fsm_state  = state_q;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    shin_d     = shin_q;
    shout_d    = shout_q;
    idx_d      = idx_q;
    todr_d     = todr_q;
    so_d       = so_q;
    wr_wcr     = 1'b0;
    wr_dr      = 1'b0;
    xfer_d2w   = 1'b0;
    xfer_w2d   = 1'b0;
    rd_src_wcr = 1'b0;
    unique case (state_q)
      ST_ADDR: if (rise_ev) begin
        shin_d = in_word;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == BYTE_LAST) begin
          cnt_d   = '0;
          state_d = (in_byte == my_addr) ? ST_INSTR : ST_SKIP;
        end
      end
      ST_INSTR: if (rise_ev) begin
        shin_d = in_word;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == BYTE_LAST) begin
          cnt_d   = '0;
          idx_d   = in_byte[DR_SEL_W-1:0];
          state_d = ST_SKIP;
          case (in_byte[7:4])
            OP_RD_WCR: begin
              rd_src_wcr = 1'b1;
              shout_d    = {{PAD_W{1'b0}}, rd_data};
              state_d    = ST_RDATA;
            end
            OP_RD_DR: begin
              shout_d = {{PAD_W{1'b0}}, rd_data};
              state_d = ST_RDATA;
            end
            OP_WR_WCR: begin
              todr_d  = 1'b0;
              state_d = ST_WDATA;
            end
            OP_WR_DR: begin
              todr_d  = 1'b1;
              state_d = ST_WDATA;
            end
            OP_DR2WCR: xfer_d2w = 1'b1;
            OP_WCR2DR: xfer_w2d = 1'b1;
            default:   state_d  = ST_SKIP;
          endcase
        end
      end
      ST_WDATA: if (rise_ev) begin
        shin_d = in_word;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == WORD_LAST) begin
          wr_wcr  = !todr_q;
          wr_dr   = todr_q;
          state_d = ST_SKIP;
        end
      end
      ST_RDATA: begin
        if (fall_ev) begin
          so_d    = shout_q[WORD_W-1];
          shout_d = {shout_q[WORD_W-2:0], 1'b0};
        end
        if (rise_ev) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == WORD_LAST) state_d = ST_SKIP;
        end
      end
      default: ;
    endcase
    if (cs_rise) begin
      state_d = ST_IDLE;
    end else if (cs_fall) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shin_q  <= '0;
      shout_q <= '0;
      idx_q   <= '0;
      todr_q  <= 1'b0;
      so_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shin_q  <= shin_d;
      shout_q <= shout_d;
      idx_q   <= idx_d;
      todr_q  <= todr_d;
      so_q    <= so_d;
    end
  end
endmodule

// File: rtl/dpot_regs.sv
`timescale 1ns/1ps
module dpot_regs #(
  parameter int WIPER_W  = 10,
  parameter int NUM_DR   = 4,
  parameter int DR_SEL_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wp_n_s,
  input  logic                        wr_wcr,
  input  logic                        wr_dr,
  input  logic                        xfer_d2w,
  input  logic                        xfer_w2d,
  input  logic [DR_SEL_W-1:0]         dr_idx,
  input  logic [WIPER_W-1:0]          wr_data,
  input  logic                        rd_src_wcr,
  input  logic [DR_SEL_W-1:0]         rd_idx,
  output logic [WIPER_W-1:0]          wiper,
  output logic [WIPER_W-1:0]          rd_data,
  output logic [NUM_DR*WIPER_W-1:0]   dr_flat,
  output logic                        recall
);
  logic [WIPER_W-1:0] wcr_q, wcr_d, dr_wval;
  logic [WIPER_W-1:0] dr_q [NUM_DR];
  logic               recall_q;
  logic               dr_store;

  assign dr_store = wp_n_s && (wr_dr || xfer_w2d);
  assign dr_wval  = wr_dr ? wr_data : wcr_q;

  always_comb begin
    wcr_d = wcr_q;
    if (recall_q)      wcr_d = dr_q[0];
    else if (wr_wcr)   wcr_d = wr_data;
    else if (xfer_d2w) wcr_d = dr_q[dr_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcr_q    <= '0;
      recall_q <= 1'b1;
    end else begin
      wcr_q    <= wcr_d;
      recall_q <= 1'b0;
    end
  end

  // storage models nonvolatile cells: deliberately untouched by rst_n
  for (genvar i = 0; i < NUM_DR; i++) begin : g_dr
    logic we;
    assign we = dr_store && (dr_idx == DR_SEL_W'(i));
    always_ff @(posedge clk) begin
      if (we) dr_q[i] <= dr_wval;
    end
    assign dr_flat[i*WIPER_W +: WIPER_W] = dr_q[i];
  end

  assign rd_data = rd_src_wcr ? wcr_q : dr_q[rd_idx];
  assign wiper   = wcr_q;
  assign recall  = recall_q;
endmodule

// File: rtl/dpot_spi_ctrl.sv
`timescale 1ns/1ps
module dpot_spi_ctrl
  import dpot_pkg::*;
#(
  parameter int         WIPER_W     = 10,
  parameter int         NUM_DR      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b0101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               si,
  input  logic               hold_n,
  input  logic               wp_n,
  input  logic [1:0]         strap,
  output logic               so,
  output logic               so_oe,
  output logic [WIPER_W-1:0] wiper
);
  localparam int DR_SEL_W = $clog2(NUM_DR);
  localparam int WORD_W   = 16;
  localparam int PIN_W    = 5;
  // pin order {wp_n, hold_n, si, sck, cs_n}; cs resets low (see dpot_link)
  localparam logic [PIN_W-1:0] PIN_RST = 5'b01000;

  logic [PIN_W-1:0] pin_s;
  logic cs_n_s, sck_s, si_s, hold_n_s, wp_n_s;
  logic sel, rise_ev, fall_ev, cs_fall, cs_rise, paused;
  logic wr_wcr, wr_dr, xfer_d2w, xfer_w2d, rd_src_wcr, so_active, recall;
  logic [DR_SEL_W-1:0]       dr_idx, rd_idx;
  logic [WIPER_W-1:0]        wr_data, rd_data;
  logic [NUM_DR*WIPER_W-1:0] dr_flat;
  st_e                       fsm_state;

  dpot_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({wp_n, hold_n, si, sck, cs_n}),
    .q(pin_s)
  );
  assign {wp_n_s, hold_n_s, si_s, sck_s, cs_n_s} = pin_s;

  dpot_link u_link (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .hold_n_s(hold_n_s),
    .sel(sel), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .paused(paused)
  );

  dpot_cmd #(.WIPER_W(WIPER_W), .WORD_W(WORD_W), .DR_SEL_W(DR_SEL_W),
             .STRAP_W(2), .DEV_TYPE(DEV_TYPE)) u_cmd (
    .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .si_s(si_s), .strap(strap),
    .rd_data(rd_data), .wr_wcr(wr_wcr), .wr_dr(wr_dr), .xfer_d2w(xfer_d2w),
    .xfer_w2d(xfer_w2d), .dr_idx(dr_idx), .wr_data(wr_data),
    .rd_src_wcr(rd_src_wcr), .rd_idx(rd_idx), .so_bit(so),
    .so_active(so_active), .fsm_state(fsm_state)
  );

  dpot_regs #(.WIPER_W(WIPER_W), .NUM_DR(NUM_DR), .DR_SEL_W(DR_SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wp_n_s(wp_n_s), .wr_wcr(wr_wcr), .wr_dr(wr_dr),
    .xfer_d2w(xfer_d2w), .xfer_w2d(xfer_w2d), .dr_idx(dr_idx), .wr_data(wr_data),
    .rd_src_wcr(rd_src_wcr), .rd_idx(rd_idx), .wiper(wiper), .rd_data(rd_data),
    .dr_flat(dr_flat), .recall(recall)
  );

  assign so_oe = so_active && !paused;
endmodule

// File: rtl/dpot_spi_ctrl_chk.sv
`timescale 1ns/1ps
module dpot_spi_ctrl_chk
  import dpot_pkg::*;
#(
  parameter int WIPER_W = 10,
  parameter int NUM_DR  = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      so,
  input logic                      so_oe,
  input logic [WIPER_W-1:0]        wiper,
  input logic                      sel,
  input logic                      paused,
  input logic                      fall_ev,
  input st_e                       fsm_state,
  input logic                      wp_n_s,
  input logic                      wr_wcr,
  input logic                      wr_dr,
  input logic                      xfer_d2w,
  input logic                      xfer_w2d,
  input logic                      recall,
  input logic [NUM_DR*WIPER_W-1:0] dr_flat
);
  assert_so_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> $past(fall_ev));

  assert_oe_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !so_oe);

  assert_pause_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    paused |=> (!sel || $stable(fsm_state)));

  assert_wiper_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper) |-> $past(wr_wcr || xfer_d2w || recall));

  assert_recall_dr0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    recall |=> (wiper == $past(dr_flat[WIPER_W-1:0])));

  assert_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n_s && (wr_dr || xfer_w2d)) |=> $stable(dr_flat));
endmodule

bind dpot_spi_ctrl dpot_spi_ctrl_chk #(.WIPER_W(WIPER_W), .NUM_DR(NUM_DR)) u_chk (
  .clk(clk), .rst_n(rst_n), .so(so), .so_oe(so_oe), .wiper(wiper),
  .sel(sel), .paused(paused), .fall_ev(fall_ev), .fsm_state(fsm_state),
  .wp_n_s(wp_n_s), .wr_wcr(wr_wcr), .wr_dr(wr_dr), .xfer_d2w(xfer_d2w),
  .xfer_w2d(xfer_w2d), .recall(recall), .dr_flat(dr_flat)
);

// File: tb/tb_dpot_spi_ctrl.sv
`timescale 1ns/1ps
module tb_dpot_spi_ctrl;
  logic clk = 1'b0;
  logic rst_n, cs_n, sck, si, hold_n, wp_n;
  logic [1:0] strap;
  logic so, so_oe;
  logic [9:0] wiper;

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_dr [4];
  logic [9:0] exp_wcr;

  always #2.5 clk = ~clk;

  dpot_spi_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .strap(strap), .so(so), .so_oe(so_oe), .wiper(wiper)
  );

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] addr_of(input logic [1:0] s);
    return {4'b0101, s, 2'b00};
  endfunction

  // mode: 0 none, 1 proper pause at bit hp, 2 hold_n falls while SCK high at bit hp
  task automatic frame(input logic [7:0] a, input logic [7:0] ins, input logic [15:0] d,
                       input int nbits, input int mode, input int hp,
                       output logic [15:0] rd, output int oe_rd, output int oe_bad);
    logic [31:0] tx;
    tx = {a, ins, d};
    rd = '0; oe_rd = 0; oe_bad = 0;
    cs_n = 1'b0; wclk(8);
    for (int k = 0; k < nbits; k++) begin
      if (mode == 1 && k == hp) begin
        hold_n = 1'b0; wclk(8);
        for (int t = 0; t < 3; t++) begin
          if (so_oe) oe_bad++;
          si = ~si; sck = 1'b1; wclk(8); sck = 1'b0; wclk(8);
        end
        if (so_oe) oe_bad++;
        hold_n = 1'b1; wclk(8);
      end
      si = tx[31-k]; wclk(8);
      if (k >= 16) begin
        rd = {rd[14:0], so};
        if (so_oe) oe_rd++;
      end else if (so_oe) oe_bad++;
      sck = 1'b1;
      if (mode == 2 && k == hp) begin
        wclk(4); hold_n = 1'b0; wclk(4);
      end else wclk(8);
      sck = 1'b0;
    end
    cs_n = 1'b1; wclk(12);
    hold_n = 1'b1; wclk(4);
    if (so_oe) oe_bad++;
  endtask

  task automatic wr_reg(input logic [3:0] op, input logic [1:0] n, input logic [15:0] d);
    logic [15:0] r; int a, b;
    frame(addr_of(strap), {op, 2'b00, n}, d, 32, 0, 0, r, a, b);
  endtask

  task automatic rd_reg(input logic [3:0] op, input logic [1:0] n, input logic [9:0] ev, input string rq);
    logic [15:0] r; int a, b;
    frame(addr_of(strap), {op, 2'b00, n}, 16'h0000, 32, 0, 0, r, a, b);
    chk(r == {6'b0, ev}, rq, {16'h0, r}, {22'h0, ev});
    chk(a == 16 && b == 0, "R2", a, 16);
  endtask

  task automatic xfer(input logic [3:0] op, input logic [1:0] n);
    logic [15:0] r; int a, b;
    frame(addr_of(strap), {op, 2'b00, n}, 16'h0, 16, 0, 0, r, a, b);
  endtask

  initial begin
    logic [15:0] r; int a, b; logic [9:0] w0, v;
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0; hold_n = 1'b1; wp_n = 1'b1;
    strap = 2'b10;
    wclk(5); rst_n = 1'b1; wclk(10);
    chk(so_oe == 1'b0, "R2 reset", so_oe, 0);
    w0 = wiper;
    // R3: chip select low since reset, no edge yet
    begin
      logic [31:0] tx; tx = {addr_of(strap), 8'hA0, 16'h0155};
      for (int k = 0; k < 32; k++) begin
        si = tx[31-k]; wclk(8); sck = 1'b1; wclk(8); sck = 1'b0;
      end
      wclk(10);
    end
    chk(wiper == w0, "R3", wiper, w0);
    cs_n = 1'b1; wclk(12);

    // R8: data registers write/read
    for (int n = 0; n < 4; n++) begin
      exp_dr[n] = 10'(100 + n * 233);
      wr_reg(4'hC, 2'(n), {6'h3F, exp_dr[n]});
    end
    for (int n = 0; n < 4; n++) rd_reg(4'hB, 2'(n), exp_dr[n], "R8");

    // R6 R7 R1: wiper sweep with non-zero padding
    for (int i = 0; i < 40; i++) begin
      v = (i == 0) ? 10'd0 : (i == 1) ? 10'd1023 : 10'((i * 137 + 3) % 1024);
      wr_reg(4'hA, 2'b00, {6'h2B, v});
      exp_wcr = v;
      chk(wiper == exp_wcr, "R7 R6", wiper, exp_wcr);
      if (i % 4 == 0) rd_reg(4'h9, 2'b00, exp_wcr, "R1");
    end

    // R12 transfers
    for (int n = 0; n < 4; n++) begin
      xfer(4'hD, 2'(n)); exp_wcr = exp_dr[n];
      chk(wiper == exp_wcr, "R12 dr->wcr", wiper, exp_wcr);
    end
    wr_reg(4'hA, 2'b00, 16'h0321); exp_wcr = 10'h321;
    xfer(4'hE, 2'd2); exp_dr[2] = exp_wcr;
    rd_reg(4'hB, 2'd2, exp_dr[2], "R12 wcr->dr");

    // R10 protect
    wp_n = 1'b0; wclk(6);
    wr_reg(4'hC, 2'd1, 16'h0077);
    rd_reg(4'hB, 2'd1, exp_dr[1], "R10 dr write blocked");
    xfer(4'hE, 2'd3);
    rd_reg(4'hB, 2'd3, exp_dr[3], "R10 xfer blocked");
    wr_reg(4'hA, 2'b00, 16'h0199); exp_wcr = 10'h199;
    chk(wiper == exp_wcr, "R10 wcr allowed", wiper, exp_wcr);
    wp_n = 1'b1; wclk(6);

    // R5 address mismatches
    begin
      logic [7:0] bad [6];
      bad[0] = addr_of(2'b00); bad[1] = addr_of(2'b01); bad[2] = addr_of(2'b11);
      bad[3] = {4'b0110, strap, 2'b00}; bad[4] = addr_of(strap) | 8'h01; bad[5] = addr_of(strap) | 8'h02;
      for (int j = 0; j < 6; j++) begin
        frame(bad[j], 8'hA0, 16'h02F0, 32, 0, 0, r, a, b);
        chk(wiper == exp_wcr, "R5 mismatch", wiper, exp_wcr);
      end
    end
    strap = 2'b01; wclk(4);
    wr_reg(4'hA, 2'b00, 16'h0044); exp_wcr = 10'h044;
    chk(wiper == exp_wcr, "R5 strap match", wiper, exp_wcr);

    // R11 unknown opcodes and aborted frames
    for (int op = 0; op < 16; op++) begin
      if (op >= 9 && op <= 14) continue;
      frame(addr_of(strap), {4'(op), 4'b0001}, 16'h03AA, 32, 0, 0, r, a, b);
      chk(wiper == exp_wcr && b == 0, "R11 opcode", wiper, exp_wcr);
    end
    frame(addr_of(strap), 8'hA0, 16'h03CC, 20, 0, 0, r, a, b);
    chk(wiper == exp_wcr, "R11 abort wcr", wiper, exp_wcr);
    frame(addr_of(strap), 8'hC1, 16'h03CC, 31, 0, 0, r, a, b);
    for (int n = 0; n < 4; n++) rd_reg(4'hB, 2'(n), exp_dr[n], "R11 drs unchanged");

    // R4 hold
    frame(addr_of(strap), 8'hA0, 16'h0256, 32, 1, 20, r, a, b);
    exp_wcr = 10'h256;
    chk(wiper == exp_wcr, "R4 paused write", wiper, exp_wcr);
    frame(addr_of(strap), 8'h90, 16'h0, 32, 1, 23, r, a, b);
    chk(r == {6'b0, exp_wcr}, "R4 paused read", r, exp_wcr);
    chk(b == 0 && a == 16, "R4 oe during pause", b, 0);
    frame(addr_of(strap), 8'hA0, 16'h0138, 32, 2, 19, r, a, b);
    exp_wcr = 10'h138;
    chk(wiper == exp_wcr, "R4 hold edge with SCK high", wiper, exp_wcr);

    // R9 R8 recall and retention
    wr_reg(4'hC, 2'd0, 16'h02C3); exp_dr[0] = 10'h2C3;
    wr_reg(4'hA, 2'b00, 16'h0005);
    rst_n = 1'b0; wclk(3); rst_n = 1'b1; wclk(6);
    chk(wiper == exp_dr[0], "R9", wiper, exp_dr[0]);
    chk(so_oe == 1'b0, "R2 after reset", so_oe, 0);
    for (int n = 0; n < 4; n++) rd_reg(4'hB, 2'(n), exp_dr[n], "R8 retained");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule